// File: doc/BRIEF.md
# I2C Target Address Front End

This block is the bit-level front end of an I2C target that runs entirely from a system clock. It oversamples the SCL and SDA wires, recognises START, repeated START and STOP, and shifts in the address phase most significant bit first. It can match either a 7-bit address or a two-byte 10-bit address, and it pulls SDA low through an open-drain enable to acknowledge.

After a match it moves data in either direction over a plain byte interface. Received bytes appear as a one-cycle strobe with the byte. Bytes to send are taken from `tx_data` in the cycle `tx_req` pulses. A 10-bit read is accepted only when the same target was fully matched by a two-byte write earlier in the same transfer, followed by a repeated START and a first byte with the read bit set.

Top module: `i2ct_addr_front`

## Requirements
- R1: After reset, `sda_oe`, `rx_valid`, `tx_req`, `addressed` and `dir_read` are all 0.
- R2: In 7-bit mode (`ten_bit_mode`=0), the first byte after START is address bits [7:1] and a direction bit [0], with 1 meaning read. When bits [7:1] equal `own_addr[6:0]`, the block pulls SDA low during the 9th clock. A write then sets `addressed`=1 and `dir_read`=0, and each data byte arrives on `rx_data` with a `rx_valid` pulse. The block changes `sda_oe` only while SCL is low.
- R3: A 7-bit address that does not match gets no acknowledge. The bytes that follow up to the next START or STOP are neither acknowledged nor delivered.
- R4: A matching 7-bit read sets `dir_read`=1 and shifts out the byte captured at each `tx_req` pulse, MSB first. The first byte is captured at the end of the address acknowledge and each further one after a controller ACK (SDA low on the 9th clock).
- R5: When the controller answers a transmitted byte with NACK (SDA high on the 9th clock), the block releases SDA and issues no further `tx_req` until a new START.
- R6: A received data byte is acknowledged and delivered only if `rx_ready`=1 when the byte completes; otherwise it gets NACK and no `rx_valid`.
- R7: In 10-bit mode, a first byte of the form 11110, A9, A8, 0 whose A9:A8 equal `own_addr[9:8]` is acknowledged. A second byte equal to `own_addr[7:0]` is then acknowledged and opens a write with `addressed`=1.
- R8: In 10-bit mode, a second byte that differs from `own_addr[7:0]` gets NACK and no data is accepted afterwards.
- R9: After a full 10-bit match, a repeated START followed by 11110, A9, A8, 1 is acknowledged and starts a transmit as in R4.
- R10: STOP clears the remembered 10-bit match. A 10-bit read first byte with no earlier full match in the same transfer gets NACK.
- R11: STOP releases SDA and returns `addressed` and `dir_read` to 0.
- R12: A 10-bit first byte whose A9:A8 differ from `own_addr[9:8]` gets NACK and also clears the remembered match, so a later repeated-START read gets NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL wire |
| sda_i | input | 1 | Sampled level of the SDA wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| own_addr | input | ADDR_W | This target's address; [6:0] in 7-bit mode, [9:0] in 10-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |
| rx_ready | input | 1 | Receiver can take a byte; 0 forces NACK |
| tx_data | input | 8 | Next byte to transmit, captured when `tx_req` pulses |
| tx_req | output | 1 | One-cycle strobe: `tx_data` was captured |
| addressed | output | 1 | Target is selected for a data phase |
| dir_read | output | 1 | Selected data phase is a read |

## Verification
The hardest state to reach is the 10-bit read. It needs a complete two-byte write match, then a repeated START issued while SCL is low with no STOP in between, and only then a read first byte, and the remembered match must survive that sequence. The stimulus gets there with a bus-controller model that builds repeated STARTs out of single bit steps. It then exercises the same read after a STOP and after a first byte with the wrong upper bits, both of which must be refused. Releasing SDA after a controller NACK is observed by clocking a further byte and reading all ones on the wired-AND bus.

// File: rtl/i2ct_pkg.sv
// Shared types and constants for the I2C target address front end.
// Assumes an 8-bit byte and the fixed 10-bit first-byte prefix.
package i2ct_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_RXB,
        ST_ACKO,
        ST_TXB,
        ST_ACKI,
        ST_PARK
    } tgt_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
// Multi-stage synchronizer for the bus wires.
// Assumes idle-high lines, so every stage resets to 1.
module i2ct_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] sync
);
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // shift each wire through its own chain of flops
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign sync[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2ct_bus_events.sv
// Derives SCL edges and START/STOP conditions from synchronized wires.
// Assumes both inputs come out of the same synchronizer depth.
module i2ct_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_p, sda_p;

    // hold the previous synchronized samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // edge and condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_evt = scl_s & scl_p & sda_p & ~sda_s;
        stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2ct_addr_match.sv
// Decides acknowledge and next phase for a completed address byte.
// Assumes ADDR_W >= 10; 7-bit mode uses own_addr[6:0].
module i2ct_addr_match
    import i2ct_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_mode,
    input  logic              second_byte,
    input  logic              hi_match,
    output logic              m_ack,
    output logic              m_read,
    output logic              m_set_hi,
    output logic              m_clr_hi,
    output tgt_state_e        m_next
);
    localparam int HI = ADDR_W - 1;

    logic upper_ok;
    assign upper_ok = (rx_byte[7:3] == TEN_PREFIX) && (rx_byte[2:1] == own_addr[HI -: 2]);

    // address comparison for first and second byte
    always_comb begin
        m_ack    = 1'b0;
        m_read   = 1'b0;
        m_set_hi = 1'b0;
        m_clr_hi = 1'b0;
        m_next   = ST_PARK;
        if (second_byte) begin
            if (rx_byte == own_addr[7:0]) begin
                m_ack    = 1'b1;
                m_set_hi = 1'b1;
                m_next   = ST_RXB;
            end else begin
                m_clr_hi = 1'b1;
            end
        end else if (ten_bit_mode) begin
            if (upper_ok && !rx_byte[0]) begin
                m_ack  = 1'b1;
                m_next = ST_ADDR2;
            end else if (upper_ok && hi_match) begin
                m_ack  = 1'b1;
                m_read = 1'b1;
                m_next = ST_TXB;
            end else begin
                m_clr_hi = 1'b1;
            end
        end else if (rx_byte[7:1] == own_addr[6:0]) begin
            m_ack  = 1'b1;
            m_read = rx_byte[0];
            m_next = rx_byte[0] ? ST_TXB : ST_RXB;
        end
    end
endmodule

// File: rtl/i2ct_byte_engine.sv
// Bit/byte sequencer: shifts address and data, drives ACK and transmit bits.
// Assumes SCL low time spans several system clocks; SDA changes on SCL low.
module i2ct_byte_engine
    import i2ct_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_hi,
    input  logic              sda_now,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_mode,
    output logic              sda_drive,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_req,
    output logic              addressed,
    output logic              dir_read
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    tgt_state_e        state, after_ack, m_next;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, txsh;
    logic              hi_match, ctl_nack;
    logic              m_ack, m_read, m_set_hi, m_clr_hi;
    logic              byte_done;

    assign byte_done = (cnt == LAST);

    i2ct_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .rx_byte     (shreg),
        .own_addr    (own_addr),
        .ten_bit_mode(ten_bit_mode),
        .second_byte (state == ST_ADDR2),
        .hi_match    (hi_match),
        .m_ack       (m_ack),
        .m_read      (m_read),
        .m_set_hi    (m_set_hi),
        .m_clr_hi    (m_clr_hi),
        .m_next      (m_next)
    );

    // main sequencer: bus conditions first, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_PARK;
            cnt       <= '0;
            shreg     <= '0;
            txsh      <= '0;
            hi_match  <= 1'b0;
            ctl_nack  <= 1'b1;
            sda_drive <= 1'b0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            tx_req    <= 1'b0;
            addressed <= 1'b0;
            dir_read  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (stop_evt) begin
                state     <= ST_IDLE;
                cnt       <= '0;
                sda_drive <= 1'b0;
                hi_match  <= 1'b0;
                addressed <= 1'b0;
                dir_read  <= 1'b0;
            end else if (start_evt) begin
                state     <= ST_ADDR1;
                cnt       <= '0;
                sda_drive <= 1'b0;
                addressed <= 1'b0;
                dir_read  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR1, ST_ADDR2, ST_RXB: begin
                        if (scl_rise && !byte_done) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_now};
                            cnt   <= cnt + 1'b1;
                        end
                        if (scl_fall && byte_done) begin
                            cnt   <= '0;
                            state <= ST_ACKO;
                            if (state == ST_RXB) begin
                                sda_drive <= rx_ready;
                                rx_valid  <= rx_ready;
                                rx_data   <= shreg;
                                after_ack <= ST_RXB;
                            end else begin
                                sda_drive <= m_ack;
                                after_ack <= m_next;
                                if (m_set_hi) hi_match <= 1'b1;
                                if (m_clr_hi) hi_match <= 1'b0;
                                if (m_next == ST_RXB || m_next == ST_TXB) begin
                                    addressed <= 1'b1;
                                    dir_read  <= m_read;
                                end
                            end
                        end
                    end
                    ST_ACKO: begin
                        if (scl_fall) begin
                            cnt       <= '0;
                            state     <= after_ack;
                            sda_drive <= 1'b0;
                            if (after_ack == ST_TXB) begin
                                txsh      <= tx_data;
                                sda_drive <= ~tx_data[BYTE_W-1];
                                tx_req    <= 1'b1;
                            end
                        end
                    end
                    ST_TXB: begin
                        if (scl_rise && !byte_done) cnt <= cnt + 1'b1;
                        if (scl_fall) begin
                            if (byte_done) begin
                                sda_drive <= 1'b0;
                                cnt       <= '0;
                                state     <= ST_ACKI;
                            end else begin
                                txsh      <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_drive <= ~txsh[BYTE_W-2];
                            end
                        end
                    end
                    ST_ACKI: begin
                        if (scl_rise) ctl_nack <= sda_now;
                        if (scl_fall) begin
                            if (!ctl_nack) begin
                                txsh      <= tx_data;
                                sda_drive <= ~tx_data[BYTE_W-1];
                                tx_req    <= 1'b1;
                                state     <= ST_TXB;
                            end else begin
                                state     <= ST_PARK;
                                addressed <= 1'b0;
                                dir_read  <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // STOP must leave the bus released and the selection cleared
    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_drive && !addressed && !dir_read));

    // the remembered 10-bit match never outlives a STOP
    assert_stop_clears_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !hi_match);

    // SDA is only ever changed while SCL is low
    assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive != $past(sda_drive)) |-> !scl_hi);

    // a delivered byte implies the receiver was ready
    assert_rx_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_ready));

    // transmit bytes are only requested in a read phase
    assert_txreq_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (dir_read && addressed));
endmodule

// File: rtl/i2ct_addr_front.sv
// Top of the I2C target front end: synchronizer, bus event decode and
// byte sequencer. Assumes external pull-ups; sda_oe=1 pulls SDA low.
module i2ct_addr_front
    import i2ct_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_mode,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_req,
    output logic              addressed,
    output logic              dir_read
);
    logic [1:0] lines_s;
    logic       scl_rise, scl_fall, start_evt, stop_evt;

    i2ct_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_i, scl_i}),
        .sync (lines_s)
    );

    i2ct_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lines_s[0]),
        .sda_s    (lines_s[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2ct_byte_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_hi      (lines_s[0]),
        .sda_now     (lines_s[1]),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .own_addr    (own_addr),
        .ten_bit_mode(ten_bit_mode),
        .sda_drive   (sda_oe),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .tx_data     (tx_data),
        .tx_req      (tx_req),
        .addressed   (addressed),
        .dir_read    (dir_read)
    );

    // START and STOP cannot be seen in the same cycle
    assert_events_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_evt, stop_evt}));
endmodule

// File: tb/sim_i2ct_addr_front.sv
// Directed bench: a bus-controller model drives SCL/SDA bit by bit.
module sim_i2ct_addr_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [9:0] own_addr = 10'h25A;
    logic       ten_bit_mode = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b1;
    logic [7:0] tx_data;
    logic       tx_req;
    logic       addressed;
    logic       dir_read;

    int vec_cnt = 0;
    int bad_cnt = 0;
    int rx_cnt = 0;
    int tx_idx = 0;
    logic [7:0] rx_last = 8'h00;
    bit finished = 0;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    function automatic logic [7:0] txv(input int i);
        return 8'h5C + 8'(i * 8'h29);
    endfunction

    assign tx_data = txv(tx_idx);

    i2ct_addr_front u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .own_addr(own_addr), .ten_bit_mode(ten_bit_mode),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_req(tx_req), .addressed(addressed), .dir_read(dir_read)
    );

    // port monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
        if (tx_req) tx_idx++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vec_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_bit(input logic b, output logic r);
        wait_n(2);  m_sda = b;
        wait_n(6);  m_scl = 1'b1;
        wait_n(4);  r = sda_bus;
        wait_n(4);  m_scl = 1'b0;
    endtask

    task automatic bus_start();
        wait_n(2);  m_sda = 1'b1;
        wait_n(8);  m_scl = 1'b1;
        wait_n(8);  m_sda = 1'b0;
        wait_n(8);  m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(2);  m_sda = 1'b0;
        wait_n(8);  m_scl = 1'b1;
        wait_n(8);  m_sda = 1'b1;
        wait_n(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) do_bit(b[i], r);
        do_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin do_bit(1'b1, r); v[i] = r; end
        do_bit(nack, r);
    endtask

    task automatic t_reset();
        check(sda_oe == 0 && rx_valid == 0 && tx_req == 0, "R1 outputs idle", {sda_oe, rx_valid, tx_req}, 0);
        check(addressed == 0 && dir_read == 0, "R1 not selected", {addressed, dir_read}, 0);
    endtask

    task automatic t_write7();
        logic a; int c0;
        ten_bit_mode = 1'b0; c0 = rx_cnt;
        bus_start();
        send_byte(8'hB4, a);
        check(a, "R2 address ack", a, 1);
        check(addressed && !dir_read, "R2 write selected", {addressed, dir_read}, 2);
        send_byte(8'h3C, a);
        check(a && rx_last == 8'h3C, "R2 first data byte", rx_last, 8'h3C);
        send_byte(8'hC3, a);
        check(a && rx_last == 8'hC3 && rx_cnt == c0 + 2, "R2 second data byte", rx_cnt - c0, 2);
        bus_stop();
        check(!addressed && !dir_read && !sda_oe, "R11 stop releases", {addressed, dir_read, sda_oe}, 0);
    endtask

    task automatic t_miss7();
        logic a; int c0;
        c0 = rx_cnt;
        bus_start();
        send_byte(8'hB6, a);
        check(!a, "R3 mismatch nack", a, 0);
        send_byte(8'h00, a);
        check(!a && rx_cnt == c0 && !addressed, "R3 following byte ignored", rx_cnt - c0, 0);
        bus_stop();
    endtask

    task automatic t_read7();
        logic a; logic [7:0] v; int b0;
        b0 = tx_idx;
        bus_start();
        send_byte(8'hB5, a);
        check(a && dir_read && addressed, "R4 read selected", {a, dir_read, addressed}, 7);
        recv_byte(1'b0, v);
        check(v == txv(b0), "R4 first tx byte", v, txv(b0));
        recv_byte(1'b1, v);
        check(v == txv(b0 + 1), "R4 second tx byte", v, txv(b0 + 1));
        recv_byte(1'b1, v);
        check(v == 8'hFF, "R5 sda released after nack", v, 8'hFF);
        check(tx_idx == b0 + 2, "R5 no extra tx_req", tx_idx - b0, 2);
        bus_stop();
    endtask

    task automatic t_notready();
        logic a; int c0;
        bus_start();
        send_byte(8'hB4, a);
        rx_ready = 1'b0; c0 = rx_cnt;
        send_byte(8'h77, a);
        check(!a && rx_cnt == c0, "R6 not ready nack", {a, 8'(rx_cnt - c0)}, 0);
        rx_ready = 1'b1;
        send_byte(8'h78, a);
        check(a && rx_last == 8'h78 && rx_cnt == c0 + 1, "R6 ready again", rx_last, 8'h78);
        bus_stop();
    endtask

    task automatic t_ten_write_read();
        logic a; logic [7:0] v; int b0;
        ten_bit_mode = 1'b1;
        bus_start();
        send_byte(8'hF4, a);
        check(a && !addressed, "R7 first byte ack", {a, addressed}, 2);
        send_byte(8'h5A, a);
        check(a && addressed && !dir_read, "R7 full match ack", {a, addressed, dir_read}, 6);
        send_byte(8'h11, a);
        check(a && rx_last == 8'h11, "R7 data byte", rx_last, 8'h11);
        b0 = tx_idx;
        bus_start();
        send_byte(8'hF5, a);
        check(a && dir_read, "R9 repeated start read ack", {a, dir_read}, 3);
        recv_byte(1'b1, v);
        check(v == txv(b0), "R9 tx byte", v, txv(b0));
        bus_stop();
    endtask

    task automatic t_ten_miss();
        logic a;
        bus_start();
        send_byte(8'hF4, a);
        send_byte(8'h5B, a);
        check(!a && !addressed, "R8 second byte mismatch", {a, addressed}, 0);
        bus_stop();
        bus_start();
        send_byte(8'hF5, a);
        check(!a, "R10 read without match nack", a, 0);
        bus_stop();
    endtask

    task automatic t_ten_upper();
        logic a;
        bus_start();
        send_byte(8'hF4, a);
        send_byte(8'h5A, a);
        bus_start();
        send_byte(8'hF2, a);
        check(!a, "R12 upper bits mismatch nack", a, 0);
        bus_start();
        send_byte(8'hF5, a);
        check(!a && !addressed, "R12 match flag cleared", {a, addressed}, 0);
        bus_stop();
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_write7();
        t_miss7();
        t_read7();
        t_notready();
        t_ten_write_read();
        t_ten_miss();
        t_ten_upper();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vec_cnt++;
            bad_cnt++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end
endmodule